// File: doc/BRIEF.md
# Touch Controller Reset and Address-Strap Sequencer

This block brings a capacitive touch controller out of reset so that the controller comes up at a known I2C address. The controller samples its interrupt pin at the moment its active-low reset pin rises, and it keeps the matching address until it is reset again. The block therefore drives that pin as a strap before it asserts reset. It keeps the strap driven through the reset pulse and for a long settling window after the release. Only then does it turn the pin driver off, so the pin can act as the controller's interrupt output.

A host raises `start` for one cycle with `sel_hi` choosing the strap level. The block holds reset low for 12 ms. It then keeps the strap for 60 ms after releasing reset, and finally reports `done` together with the 7-bit address the controller latched. All delays are counted in clock cycles derived from the `CLK_HZ` parameter. A later start repeats the whole sequence, possibly with a different strap level.

Top module: `touch_rst_seq`

## Requirements
- R1: After the block's reset, `tp_rst_n` is 1, `int_oe` is 0, `done` is 0 and `addr` is 7'h00.
- R2: In the cycle after an accepted start, `int_oe` is 1 and `int_o` equals the sampled `sel_hi`, while `tp_rst_n` is still 1. The strap is driven at least one cycle before reset falls.
- R3: `tp_rst_n` stays 0 for exactly CLK_HZ/1000 × RST_MS cycles (12 ms by default), with `int_oe` at 1 throughout.
- R4: After `tp_rst_n` rises, `int_oe` stays 1 for exactly CLK_HZ/1000 × HOLD_MS cycles (60 ms by default), and `int_o` does not change from the start of the sequence until the driver is released. After that, `int_oe` is 0.
- R5: A strap level of 0 (`sel_hi`=0) yields `addr` = 7'h5D and a level of 1 yields `addr` = 7'h14. `addr` changes only in the cycle in which `int_oe` falls.
- R6: `done` rises in the same cycle that `int_oe` falls, and it stays at 1 while idle.
- R7: While a sequence runs, `start` pulses and changes on `sel_hi` have no effect on the pin timing, the strap level or the final address.
- R8: A start accepted while idle clears `done` and reruns the full sequence; the new run may use a different strap level, and its address replaces the previous one.
- R9: While idle, `tp_rst_n` is 1 and `int_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start | input | 1 | Request to run the sequence, accepted only when idle |
| sel_hi | input | 1 | Strap level: 0 selects 7'h5D, 1 selects 7'h14 |
| tp_rst_n | output | 1 | Active-low reset to the touch controller |
| int_o | output | 1 | Level driven onto the interrupt pin |
| int_oe | output | 1 | Output enable for the interrupt pin driver |
| done | output | 1 | Sequence complete |
| addr | output | 7 | Address latched by the controller |

## Verification
The bench counts the reset-low and post-release hold cycles of every run exactly. A sequencer that is off by one cycle in either window, or that shortens the hold, is therefore caught. It also toggles `start` and `sel_hi` at random during runs, including the last hold cycle. A design that restarts, or that re-samples the strap mid-run, would show a changed strap level or a wrong address. Back-to-back runs with alternating straps expose an address or `done` flag that fails to refresh. A design that enables the driver only together with reset fails the one-cycle setup check.

// File: rtl/touch_rst_seq.sv
module touch_rst_seq #(
  parameter int CLK_HZ = 100_000_000,
  parameter int RST_MS = 12,
  parameter int HOLD_MS = 60,
  parameter logic [6:0] ADDR_LOW = 7'h5D,
  parameter logic [6:0] ADDR_HIGH = 7'h14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sel_hi,
  output logic       tp_rst_n,
  output logic       int_o,
  output logic       int_oe,
  output logic       done,
  output logic [6:0] addr
);
  localparam int CYC_PER_MS = CLK_HZ / 1000;
  localparam int RST_CYC = CYC_PER_MS * RST_MS;
  localparam int HOLD_CYC = CYC_PER_MS * HOLD_MS;
  localparam int MAX_CYC = (RST_CYC > HOLD_CYC) ? RST_CYC : HOLD_CYC;
  localparam int CW = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_RST, S_HOLD} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      lvl  <= 1'b0;
      done <= 1'b0;
      addr <= 7'h00;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          lvl  <= sel_hi;
          done <= 1'b0;
          st   <= S_SETUP;
        end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_RST;
        end
        S_RST: if (cnt == CW'(RST_CYC - 1)) begin
          cnt <= '0;
          st  <= S_HOLD;
        end else cnt <= cnt + 1'b1;
        S_HOLD: if (cnt == CW'(HOLD_CYC - 1)) begin
          cnt  <= '0;
          st   <= S_IDLE;
          done <= 1'b1;
          addr <= lvl ? ADDR_HIGH : ADDR_LOW;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign tp_rst_n = (st != S_RST);
  assign int_oe   = (st != S_IDLE);
  assign int_o    = lvl;
endmodule

// File: rtl/touch_rst_seq_chk.sv
module touch_rst_seq_chk #(
  parameter int RST_CYC = 12,
  parameter logic [6:0] ADDR_LOW = 7'h5D,
  parameter logic [6:0] ADDR_HIGH = 7'h14
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tp_rst_n,
  input logic       int_o,
  input logic       int_oe,
  input logic       done,
  input logic [6:0] addr
);
  logic [31:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!tp_rst_n) low_cnt <= low_cnt + 1;
    else low_cnt <= '0;
  end

  // R2
  strap_before_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tp_rst_n) |-> $past(int_oe));

  // R3
  strap_during_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tp_rst_n |-> int_oe);

  // R3
  reset_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tp_rst_n) |-> low_cnt == 32'(RST_CYC));

  // R4
  strap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_oe && $past(int_oe)) |-> $stable(int_o));

  // R5
  addr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr) |-> $fell(int_oe));

  // R5
  addr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_oe) |-> addr == ($past(int_o) ? ADDR_HIGH : ADDR_LOW));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(int_oe));

  // R9
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tp_rst_n && !int_oe));
endmodule

bind touch_rst_seq touch_rst_seq_chk #(
  .RST_CYC(RST_CYC), .ADDR_LOW(ADDR_LOW), .ADDR_HIGH(ADDR_HIGH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tp_rst_n(tp_rst_n), .int_o(int_o),
  .int_oe(int_oe), .done(done), .addr(addr)
);

// File: tb/tb_touch_rst_seq.sv
`timescale 1ns/1ps
module tb_touch_rst_seq;
  localparam int CLK_HZ = 10_000;
  localparam int RST_CYC = CLK_HZ / 1000 * 12;
  localparam int HOLD_CYC = CLK_HZ / 1000 * 60;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sel_hi = 1'b0;
  logic tp_rst_n, int_o, int_oe, done;
  logic [6:0] addr;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  touch_rst_seq #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_hi(sel_hi),
    .tp_rst_n(tp_rst_n), .int_o(int_o), .int_oe(int_oe),
    .done(done), .addr(addr)
  );

  function automatic logic [6:0] exp_addr(input logic s);
    return s ? 7'h14 : 7'h5D;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_seq(input logic s, input bit noisy);
    int lows = 0, holds = 0, guard = 0;
    bit bad_oe = 0, bad_lvl = 0;
    @(negedge clk);
    start = 1'b1; sel_hi = s;
    @(negedge clk);
    start = 1'b0;
    check("R2 oe at setup", int_oe, 1);
    check("R2 level at setup", int_o, s);
    check("R2 reset still high", tp_rst_n, 1);
    check("R8 done cleared", done, 0);
    while (int_oe) begin
      if (!tp_rst_n) lows++;
      else if (lows > 0) holds++;
      if (int_o != s) bad_lvl = 1;
      if (!tp_rst_n && !int_oe) bad_oe = 1;
      guard++;
      if (guard > RST_CYC + HOLD_CYC + 20) begin
        check("R4 sequence ends", 0, 1);
        break;
      end
      if (noisy) begin
        // R7: pulses and strap changes mid-run
        start = ($urandom_range(0, 9) == 0) || (holds == HOLD_CYC);
        sel_hi = $urandom_range(0, 1) == 1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check("R3 reset low cycles", lows, RST_CYC);
    check("R4 hold cycles", holds, HOLD_CYC);
    check("R7 strap level stable", bad_lvl, 0);
    check("R3 oe during reset", bad_oe, 0);
    check("R6 done at release", done, 1);
    check("R5 address", addr, exp_addr(s));
    repeat (3) @(negedge clk);
    check("R9 idle reset high", tp_rst_n, 1);
    check("R9 idle oe low", int_oe, 0);
    check("R6 done held", done, 1);
    check("R5 address held", addr, exp_addr(s));
  endtask

  initial begin
    #5_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset pin", tp_rst_n, 1);
    check("R1 oe", int_oe, 0);
    check("R1 done", done, 0);
    check("R1 addr", addr, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 idle oe", int_oe, 0);
    run_seq(1'b0, 0);
    run_seq(1'b1, 0);
    run_seq(1'b1, 1);
    run_seq(1'b0, 1);
    for (int i = 0; i < 5; i++) run_seq($urandom_range(0, 1) == 1, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule